// File: doc/BRIEF.md
# Arithmetic Right Shift Unit with Condition Flags

This execution-stage block shifts a 32-bit source operand to the right while preserving its sign. Every vacated upper bit takes a copy of the original most significant bit. The shift distance comes from one of two places. One is the low bits of a second register operand. The other is a short immediate field, and any upper bits of that field are dropped. A two-bit form code selects the amount source. It also selects where the result goes: back to the register that was shifted, or to a separate destination register index.

The block also produces new values for four condition flags. The carry flag holds the last bit that fell off the bottom of the source. It is zero when nothing is shifted. The overflow flag is always cleared. The sign and zero flags describe the result. A five-bit write mask tells the flag register which flags to update, and the saturation flag is never among them. One register stage sits between the operands and all outputs, so a valid request appears one clock later.

Top module: `sra_flag_unit`

## Requirements
- R1: In forms 0 and 2 the shift amount is `in_amt_reg[4:0]` (0 to 31). Bits 31:5 of `in_amt_reg` have no effect.
- R2: In form 1 the shift amount is `in_amt_imm[4:0]`. Bits 7:5 of `in_amt_imm` have no effect.
- R3: The result equals the source shifted right by the amount, with every vacated high bit equal to source bit 31.
- R4: With an amount of 0 the result equals the source unchanged, and the carry output is 0.
- R5: With an amount n of 1 to 31, the carry output equals source bit n-1.
- R6: The overflow output is 0 after every valid operation, and mask bit 2 (overflow) is set for every legal form.
- R7: The sign output equals result bit 31, and the zero output is 1 exactly when the result is all zeros.
- R8: Flag mask bit layout is {4: saturation, 3: carry, 2: overflow, 1: sign, 0: zero}. A legal valid operation gives mask 5'b01111. Bit 4 is never set.
- R9: Forms 0 and 1 write to `in_src_idx`. Form 2 writes to `in_dst_idx`. A legal valid operation raises `out_wr_en`.
- R10: Form 3 is reserved. It still yields `out_valid`, but `out_wr_en` is 0 and the mask is 0.
- R11: `out_valid` follows `in_valid` one cycle later. In a cycle after `in_valid` was low, `out_wr_en` and the mask are 0, and result and flags keep their previous values.
- R12: A synchronous active-high reset clears `out_valid`, `out_wr_en`, the mask, the result, the index and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request this cycle |
| in_form | input | 2 | 0: register amount, in place; 1: immediate amount, in place; 2: register amount, separate destination; 3: reserved |
| in_src | input | 32 | Value to be shifted |
| in_amt_reg | input | 32 | Register operand holding the shift amount |
| in_amt_imm | input | 8 | Immediate shift amount field |
| in_src_idx | input | 5 | Index of the shifted register |
| in_dst_idx | input | 5 | Separate destination index for form 2 |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 32 | Shifted value |
| out_wr_idx | output | 5 | Register index to write |
| out_wr_en | output | 1 | Register write enable |
| out_cy | output | 1 | New carry flag |
| out_ov | output | 1 | New overflow flag |
| out_s | output | 1 | New sign flag |
| out_z | output | 1 | New zero flag |
| out_flag_mask | output | 5 | Which flags to update, layout as in R8 |

## Verification
The assertions assume four things. Reset is applied before the first request. `in_form` always holds one of its four defined codes. Every input is free of unknown values in cycles where `in_valid` is high. Each operand is held for exactly the edge that captures it. The bench meets these assumptions by holding reset for several cycles with all inputs driven to zero. It changes inputs only on the falling edge and drives only numeric constants or random words, so no unknown value is ever presented.

// File: rtl/sra_pkg.sv
package sra_pkg;

   typedef enum logic [1:0] {
      FORM_REG_INPLACE = 2'd0,
      FORM_IMM_INPLACE = 2'd1,
      FORM_REG_SPLIT   = 2'd2,
      FORM_RESERVED    = 2'd3
   } sra_form_e;

   localparam int FLAG_Z   = 0;
   localparam int FLAG_S   = 1;
   localparam int FLAG_OV  = 2;
   localparam int FLAG_CY  = 3;
   localparam int FLAG_SAT = 4;
   localparam int FLAG_N   = 5;

   typedef struct packed {
      logic cy;
      logic ov;
      logic s;
      logic z;
   } sra_flags_t;

endpackage

// File: rtl/sra_operand_sel.sv
module sra_operand_sel
   import sra_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int IDX_W  = 5,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [1:0]        form,
   input  logic [DATA_W-1:0] amt_reg,
   input  logic [IMM_W-1:0]  amt_imm,
   input  logic [IDX_W-1:0]  src_idx,
   input  logic [IDX_W-1:0]  dst_idx,
   output logic [AMT_W-1:0]  amt,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              legal
);

   logic [AMT_W-1:0] imm_amt;
   logic [AMT_W-1:0] reg_amt;
   sra_form_e        form_e;

   assign form_e  = sra_form_e'(form);
   assign reg_amt = amt_reg[AMT_W-1:0];

   logic unused_reg_hi;
   assign unused_reg_hi = ^amt_reg[DATA_W-1:AMT_W];

   generate
      if (IMM_W > AMT_W) begin : g_imm_trunc
         logic unused_imm_hi;
         assign unused_imm_hi = ^amt_imm[IMM_W-1:AMT_W];
         assign imm_amt       = amt_imm[AMT_W-1:0];
      end else if (IMM_W == AMT_W) begin : g_imm_exact
         assign imm_amt = amt_imm;
      end else begin : g_imm_ext
         assign imm_amt = AMT_W'(amt_imm);
      end
   endgenerate

   always_comb begin
      amt    = reg_amt;
      wr_idx = src_idx;
      legal  = 1'b1;
      unique case (form_e)
         FORM_REG_INPLACE: begin amt = reg_amt; wr_idx = src_idx; end
         FORM_IMM_INPLACE: begin amt = imm_amt; wr_idx = src_idx; end
         FORM_REG_SPLIT:   begin amt = reg_amt; wr_idx = dst_idx; end
         default:          begin legal = 1'b0; end
      endcase
   end

endmodule

// File: rtl/sra_barrel.sv
module sra_barrel #(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W),
   localparam int EXT_W = DATA_W + 1
) (
   input  logic [DATA_W-1:0] src,
   input  logic [AMT_W-1:0]  amt,
   output logic [DATA_W-1:0] res,
   output logic              cy
);

   // A guard bit below the source collects the last bit shifted out.
   logic [EXT_W-1:0] stg [0:AMT_W];
   logic             fill;

   assign fill   = src[DATA_W-1];
   assign stg[0] = {src, 1'b0};

   generate
      for (genvar k = 0; k < AMT_W; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign stg[k+1] = amt[k] ? {{SH{fill}}, stg[k][EXT_W-1:SH]} : stg[k];
      end
   endgenerate

   assign res = stg[AMT_W][EXT_W-1:1];
   assign cy  = stg[AMT_W][0];

endmodule

// File: rtl/sra_flag_gen.sv
module sra_flag_gen
   import sra_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] res,
   input  logic              cy_in,
   output sra_flags_t        flags
);

   always_comb begin
      flags.cy = cy_in;
      flags.ov = 1'b0;
      flags.s  = res[DATA_W-1];
      flags.z  = (res == '0);
   end

endmodule

// File: rtl/sra_flag_unit.sv
module sra_flag_unit
   import sra_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [1:0]        in_form,
   input  logic [DATA_W-1:0] in_src,
   input  logic [DATA_W-1:0] in_amt_reg,
   input  logic [IMM_W-1:0]  in_amt_imm,
   input  logic [IDX_W-1:0]  in_src_idx,
   input  logic [IDX_W-1:0]  in_dst_idx,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic [IDX_W-1:0]  out_wr_idx,
   output logic              out_wr_en,
   output logic              out_cy,
   output logic              out_ov,
   output logic              out_s,
   output logic              out_z,
   output logic [FLAG_N-1:0] out_flag_mask
);

   localparam int AMT_W = $clog2(DATA_W);
   localparam logic [FLAG_N-1:0] WR_MASK =
      FLAG_N'((1 << FLAG_Z) | (1 << FLAG_S) | (1 << FLAG_OV) | (1 << FLAG_CY));

   generate
      if (DATA_W < 2 || (1 << AMT_W) != DATA_W) begin : g_bad_width
         $error("sra_flag_unit: DATA_W must be a power of two of at least 2");
      end
      if (IMM_W < 1 || IDX_W < 1) begin : g_bad_field
         $error("sra_flag_unit: IMM_W and IDX_W must be at least 1");
      end
   endgenerate

   logic [AMT_W-1:0]  sel_amt;
   logic [IDX_W-1:0]  sel_idx;
   logic              sel_legal;
   logic [DATA_W-1:0] sh_res;
   logic              sh_cy;
   sra_flags_t        flg;

   sra_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) i_sel (
      .form    (in_form),
      .amt_reg (in_amt_reg),
      .amt_imm (in_amt_imm),
      .src_idx (in_src_idx),
      .dst_idx (in_dst_idx),
      .amt     (sel_amt),
      .wr_idx  (sel_idx),
      .legal   (sel_legal)
   );

   sra_barrel #(.DATA_W(DATA_W)) i_barrel (
      .src (in_src),
      .amt (sel_amt),
      .res (sh_res),
      .cy  (sh_cy)
   );

   sra_flag_gen #(.DATA_W(DATA_W)) i_flags (
      .res   (sh_res),
      .cy_in (sh_cy),
      .flags (flg)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid     <= 1'b0;
         out_wr_en     <= 1'b0;
         out_flag_mask <= '0;
         out_result    <= '0;
         out_wr_idx    <= '0;
         out_cy        <= 1'b0;
         out_ov        <= 1'b0;
         out_s         <= 1'b0;
         out_z         <= 1'b0;
      end else begin
         out_valid     <= in_valid;
         out_wr_en     <= in_valid & sel_legal;
         out_flag_mask <= (in_valid & sel_legal) ? WR_MASK : '0;
         if (in_valid) begin
            out_result <= sh_res;
            out_wr_idx <= sel_idx;
            out_cy     <= flg.cy;
            out_ov     <= flg.ov;
            out_s      <= flg.s;
            out_z      <= flg.z;
         end
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && !out_wr_en && out_flag_mask == '0)); // R11
   AST_OV_CLEARED: assert property (@(posedge clk) disable iff (rst) out_valid |-> !out_ov); // R6
   AST_SAT_UNTOUCHED: assert property (@(posedge clk) disable iff (rst) out_valid |-> !out_flag_mask[FLAG_SAT]); // R8
   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst) out_valid |-> (out_z == (out_result == '0))); // R7
   AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (rst) out_valid |-> (out_s == out_result[DATA_W-1])); // R7
   AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst) (in_valid && in_src[DATA_W-1]) |=> out_result[DATA_W-1]); // R3
   AST_ZERO_AMT_PASS: assert property (@(posedge clk) disable iff (rst) (in_valid && sel_amt == '0) |=> (out_result == $past(in_src) && !out_cy)); // R4
   AST_SPLIT_IDX: assert property (@(posedge clk) disable iff (rst) (in_valid && in_form == 2'd2) |=> (out_wr_en && out_wr_idx == $past(in_dst_idx))); // R9
   AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (in_valid && in_form == 2'd3) |=> (!out_wr_en && out_flag_mask == '0)); // R10

endmodule

// File: tb/test_sra_flag_unit.sv
module test_sra_flag_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [1:0]  in_form = 2'd0;
   logic [31:0] in_src = '0;
   logic [31:0] in_amt_reg = '0;
   logic [7:0]  in_amt_imm = '0;
   logic [4:0]  in_src_idx = '0;
   logic [4:0]  in_dst_idx = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic [4:0]  out_wr_idx;
   logic        out_wr_en;
   logic        out_cy, out_ov, out_s, out_z;
   logic [4:0]  out_flag_mask;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sra_flag_unit i_sra_flag_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_form(in_form),
      .in_src(in_src), .in_amt_reg(in_amt_reg), .in_amt_imm(in_amt_imm),
      .in_src_idx(in_src_idx), .in_dst_idx(in_dst_idx),
      .out_valid(out_valid), .out_result(out_result), .out_wr_idx(out_wr_idx),
      .out_wr_en(out_wr_en), .out_cy(out_cy), .out_ov(out_ov), .out_s(out_s),
      .out_z(out_z), .out_flag_mask(out_flag_mask)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Drive one request on a falling edge; check on the following falling edge.
   task automatic run_op(input logic [1:0] f, input logic [31:0] s, input logic [31:0] a,
                         input logic [7:0] im, input logic [4:0] si, input logic [4:0] di,
                         input string req);
      int          n;
      logic [31:0] exp_res;
      logic        exp_cy;
      @(negedge clk);
      in_valid = 1'b1; in_form = f; in_src = s; in_amt_reg = a;
      in_amt_imm = im; in_src_idx = si; in_dst_idx = di;
      @(negedge clk);
      in_valid = 1'b0;
      n       = (f == 2'd1) ? int'(im[4:0]) : int'(a[4:0]);
      exp_res = 32'($signed(s) >>> n);
      exp_cy  = (n == 0) ? 1'b0 : s[n-1];
      chk(req, "valid", 32'(out_valid), 32'd1);
      chk(req, "result", out_result, exp_res);
      chk(req, "cy", 32'(out_cy), 32'(exp_cy));
      chk("R6", "ov", 32'(out_ov), 32'd0);
      chk("R7", "s", 32'(out_s), 32'(exp_res[31]));
      chk("R7", "z", 32'(out_z), 32'(exp_res == 32'd0));
      if (f == 2'd3) begin
         chk("R10", "wr_en", 32'(out_wr_en), 32'd0);
         chk("R10", "mask", 32'(out_flag_mask), 32'd0);
      end else begin
         chk("R9", "wr_en", 32'(out_wr_en), 32'd1);
         chk("R8", "mask", 32'(out_flag_mask), 32'h0F);
         chk("R9", "wr_idx", 32'(out_wr_idx), 32'((f == 2'd2) ? di : si));
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R12", "valid", 32'(out_valid), 32'd0);
      chk("R12", "wr_en", 32'(out_wr_en), 32'd0);
      chk("R12", "mask", 32'(out_flag_mask), 32'd0);
      chk("R12", "result", out_result, 32'd0);
      chk("R12", "flags", 32'({out_cy, out_ov, out_s, out_z}), 32'd0);
      chk("R12", "wr_idx", 32'(out_wr_idx), 32'd0);
   endtask

   task automatic t_boundaries();
      run_op(2'd0, 32'h1234_5678, 32'd0,  8'd0, 5'd3, 5'd9, "R4");
      run_op(2'd0, 32'h8765_4321, 32'd0,  8'd0, 5'd3, 5'd9, "R4");
      run_op(2'd0, 32'h0000_0003, 32'd1,  8'd0, 5'd4, 5'd9, "R5");
      run_op(2'd0, 32'hF000_0002, 32'd1,  8'd0, 5'd4, 5'd9, "R5");
      run_op(2'd0, 32'h7FFF_FFFF, 32'd31, 8'd0, 5'd5, 5'd9, "R3");
      run_op(2'd0, 32'h8000_0000, 32'd31, 8'd0, 5'd5, 5'd9, "R3");
      run_op(2'd0, 32'hC000_0000, 32'd30, 8'd0, 5'd6, 5'd9, "R5");
      run_op(2'd0, 32'h0000_0001, 32'd1,  8'd0, 5'd7, 5'd9, "R7");
   endtask

   task automatic t_amount_masking();
      run_op(2'd0, 32'hA5A5_0F0F, 32'hFFFF_FFE4, 8'hFF, 5'd1, 5'd2, "R1");
      run_op(2'd2, 32'h8000_1000, 32'h1234_5620, 8'h00, 5'd1, 5'd2, "R1");
      run_op(2'd1, 32'hA5A5_0F0F, 32'h0000_001F, 8'hE3, 5'd8, 5'd2, "R2");
      run_op(2'd1, 32'hF0F0_0001, 32'h0000_0004, 8'hA0, 5'd8, 5'd2, "R2");
   endtask

   task automatic t_split_and_reserved();
      run_op(2'd2, 32'h8001_0000, 32'd16, 8'd0, 5'd10, 5'd21, "R9");
      run_op(2'd1, 32'h0001_0000, 32'd0,  8'd16, 5'd10, 5'd21, "R9");
      run_op(2'd3, 32'h0000_00F0, 32'd4,  8'd0,  5'd10, 5'd21, "R10");
   endtask

   task automatic t_idle_hold();
      logic [31:0] prev_res;
      logic [3:0]  prev_flg;
      run_op(2'd0, 32'hFFFF_0000, 32'd17, 8'd0, 5'd2, 5'd3, "R3");
      prev_res = out_result;
      prev_flg = {out_cy, out_ov, out_s, out_z};
      in_src = 32'h0; in_amt_reg = 32'd0;
      @(negedge clk);
      chk("R11", "valid", 32'(out_valid), 32'd0);
      chk("R11", "wr_en", 32'(out_wr_en), 32'd0);
      chk("R11", "mask", 32'(out_flag_mask), 32'd0);
      chk("R11", "result held", out_result, prev_res);
      chk("R11", "flags held", 32'({out_cy, out_ov, out_s, out_z}), 32'(prev_flg));
   endtask

   task automatic t_random();
      for (int i = 0; i < 60; i++) begin
         logic [31:0] s, a;
         logic [7:0]  im;
         logic [1:0]  f;
         s  = $urandom();
         a  = $urandom();
         im = 8'($urandom());
         f  = 2'($urandom_range(0, 2));
         run_op(f, s, a, im, 5'($urandom()), 5'($urandom()), "R3");
      end
   endtask

   task automatic t_reset_midstream();
      @(negedge clk);
      in_valid = 1'b1; in_form = 2'd0; in_src = 32'h8000_0001; in_amt_reg = 32'd1;
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R12", "valid", 32'(out_valid), 32'd0);
      chk("R12", "result", out_result, 32'd0);
      chk("R12", "flags", 32'({out_cy, out_ov, out_s, out_z}), 32'd0);
      chk("R12", "mask", 32'(out_flag_mask), 32'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_boundaries();
      t_amount_masking();
      t_split_and_reserved();
      t_idle_hold();
      t_random();
      t_reset_midstream();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule